// File: doc/BRIEF.md
# ADC conversion sequencer controller

This block is the digital control for a successive-approximation converter whose analog part sits outside it. It runs an acquisition phase, then a conversion phase of fourteen conversion-clock periods (TAD), then writes the converter's data word into a result register and pulses a completion flag. The system clock `clk` runs at twice the instruction rate, so one `clk` period is half an instruction cycle. A TAD is therefore `adcs + 1` clock periods, giving 64 settings in half-instruction-cycle steps. A select bit can instead take each TAD from single-cycle pulses on `rc_tick`, which come from a free-running oscillator synchronised outside the block.

The end of acquisition, which is the start of conversion, comes from one of four sources picked by `trig_sel`:
- the software sample bit `samp_bit` going low;
- a pulse on the external-interrupt input;
- a pulse on the timer input;
- an automatic count of `samc` TAD periods.

In the automatic mode, a new acquisition starts as soon as a conversion completes, so samples run back to back. Pulling `enable` low stops any phase in progress and throws away the partial conversion.

Settings are captured when an acquisition starts, so changing the control inputs never disturbs a sample already under way.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `acq_active`, `conv_active` and `done` are 0 and `result` is 0.
- R2: With `rc_sel` = 0, one TAD equals `adcs + 1` clock periods and `conv_active` stays high for exactly 14 × (`adcs` + 1) cycles.
- R3: With `trig_sel` = 000 (software), `enable` high in idle and `samp_bit` sampled 1 raises `acq_active` on the next cycle. `samp_bit` sampled 0 during acquisition starts the conversion on the next cycle. When the conversion completes, the block returns to idle.
- R4: With `trig_sel` = 111 (automatic), acquisition lasts `samc` × (`adcs` + 1) cycles, and a `samc` of 0 acts as 1. In the cycle `done` is high, `acq_active` is already high again.
- R5: With `trig_sel` = 001, only a pulse on `ext_trig` ends acquisition. Any other non-automatic, non-software value (010 to 110) makes only a pulse on `tmr_trig` end acquisition. The conversion starts in the cycle after the pulse, and the unselected pulse and `samp_bit` have no effect.
- R6: With `rc_sel` = 1, each `rc_tick` pulse sampled during a conversion counts as one TAD. The conversion ends at the edge that samples the 14th pulse.
- R7: `done` is high for exactly one cycle per completed conversion. In that same cycle `result` holds the value `conv_data` had at the edge that raised `done`.
- R8: `enable` sampled 0 ends any phase on the next cycle, with no `done` and `result` unchanged. After `enable` returns, no acquisition starts until `samp_bit` is sampled 1.
- R9: If `enable` is sampled 0 at the edge where an automatic count expires, no conversion starts.
- R10: Changes to `trig_sel`, `samc`, `adcs` and `rc_sel` during a phase take effect only at the next acquisition start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the instruction rate |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Module enable; low aborts |
| trig_sel | input | 3 | Conversion trigger source select |
| samp_bit | input | 1 | Software sample-control bit |
| samc | input | 5 | Automatic acquisition length in TAD |
| adcs | input | 6 | TAD divider setting |
| rc_sel | input | 1 | Take TAD from `rc_tick` |
| rc_tick | input | 1 | One pulse per oscillator TAD |
| tmr_trig | input | 1 | Timer trigger pulse |
| ext_trig | input | 1 | External-interrupt trigger pulse |
| conv_data | input | DATA_W | Data word from the converter |
| acq_active | output | 1 | Acquisition phase in progress |
| conv_active | output | 1 | Conversion phase in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DATA_W | Result buffer |

## Verification
The main sequence is driven in the automatic mode from a table of divider and sample-count pairs. The table includes a divider of 0, the largest divider, a sample count of 0 and the largest sample count, so that off-by-one errors in either counter show up as wrong phase lengths. Each non-automatic source is run with the competing inputs pulsed while it waits, which tells a correct select decode apart from one that listens to the wrong input. The oscillator mode uses sparse pulses, so counting clocks instead of pulses ends the conversion early. Abort and settings changes are tested mid-phase and at the exact edge where the automatic count expires.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int ADCS_W   = 6;
    localparam int SAMC_W   = 5;
    localparam int TSEL_W   = 3;
    localparam int CONV_TAD = 14;
    localparam int TCNT_W   = (SAMC_W > $clog2(CONV_TAD + 1)) ? SAMC_W : $clog2(CONV_TAD + 1);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACQ,
        ST_CONV
    } seq_state_e;

    typedef enum logic [1:0] {
        TK_SOFT,
        TK_EXT,
        TK_TIMER,
        TK_AUTO
    } trig_kind_e;

    typedef struct packed {
        trig_kind_e          kind;
        logic [SAMC_W-1:0]   samc;
        logic [ADCS_W-1:0]   div;
        logic                rc;
    } seq_cfg_t;

    function automatic trig_kind_e decode_trig(input logic [TSEL_W-1:0] sel);
        trig_kind_e k;
        case (sel)
            3'b000:  k = TK_SOFT;
            3'b111:  k = TK_AUTO;
            3'b001:  k = TK_EXT;
            default: k = TK_TIMER;
        endcase
        return k;
    endfunction

    function automatic logic [SAMC_W-1:0] samc_floor(input logic [SAMC_W-1:0] s);
        return (s == '0) ? SAMC_W'(1) : s;
    endfunction

endpackage

// File: rtl/adc_tad_gen.sv
module adc_tad_gen
    import adc_seq_pkg::*;
#(
    parameter int DIV_W = ADCS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  logic             use_rc,
    input  logic             rc_tick,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = (cnt == div);

    always_ff @(posedge clk) begin
        if (rst || clr || !run) begin
            cnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    generate
        if (DIV_W > 0) begin : g_sel
            always_comb begin
                if (!run)       tick = 1'b0;
                else if (use_rc) tick = rc_tick;
                else            tick = wrap;
            end
        end
    endgenerate

endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
(
    input  trig_kind_e kind,
    input  logic       samp_bit,
    input  logic       ext_trig,
    input  logic       tmr_trig,
    output logic       req
);

    always_comb begin
        unique case (kind)
            TK_SOFT:  req = !samp_bit;
            TK_EXT:   req = ext_trig;
            TK_TIMER: req = tmr_trig;
            default:  req = 1'b0;
        endcase
    end

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              samp_bit,
    input  seq_cfg_t          cfg_in,
    input  logic              trig_req,
    input  logic              tick,
    input  logic [DATA_W-1:0] conv_data,
    output seq_cfg_t          cfg,
    output logic              tad_clr,
    output logic              run,
    output logic              acq_active,
    output logic              conv_active,
    output logic              done,
    output logic [DATA_W-1:0] result
);

    seq_state_e        st, nxt;
    logic [TCNT_W-1:0] tcnt;
    logic              load;
    logic              fin;
    logic              acq_end;
    logic              conv_end;

    always_comb begin
        if (cfg.kind == TK_AUTO)
            acq_end = tick && (tcnt == TCNT_W'(samc_floor(cfg.samc) - 1'b1));
        else
            acq_end = trig_req;
        conv_end = tick && (tcnt == TCNT_W'(CONV_TAD - 1));
    end

    always_comb begin
        nxt     = st;
        load    = 1'b0;
        tad_clr = 1'b0;
        fin     = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (enable && samp_bit) begin
                    nxt     = ST_ACQ;
                    load    = 1'b1;
                    tad_clr = 1'b1;
                end
            end
            ST_ACQ: begin
                if (!enable) begin
                    nxt = ST_IDLE;
                end else if (acq_end) begin
                    nxt     = ST_CONV;
                    tad_clr = 1'b1;
                end
            end
            ST_CONV: begin
                if (!enable) begin
                    nxt = ST_IDLE;
                end else if (conv_end) begin
                    fin     = 1'b1;
                    tad_clr = 1'b1;
                    if (cfg.kind == TK_AUTO) begin
                        nxt  = ST_ACQ;
                        load = 1'b1;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            tcnt   <= '0;
            cfg    <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            st   <= nxt;
            done <= fin;
            if (tad_clr)   tcnt <= '0;
            else if (tick) tcnt <= tcnt + 1'b1;
            if (load) cfg <= cfg_in;
            if (fin)  result <= conv_data;
        end
    end

    assign run         = (st != ST_IDLE);
    assign acq_active  = (st == ST_ACQ);
    assign conv_active = (st == ST_CONV);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [2:0]        trig_sel,
    input  logic              samp_bit,
    input  logic [4:0]        samc,
    input  logic [5:0]        adcs,
    input  logic              rc_sel,
    input  logic              rc_tick,
    input  logic              tmr_trig,
    input  logic              ext_trig,
    input  logic [DATA_W-1:0] conv_data,
    output logic              acq_active,
    output logic              conv_active,
    output logic              done,
    output logic [DATA_W-1:0] result
);

    seq_cfg_t cfg_in;
    seq_cfg_t cfg;
    logic     trig_req;
    logic     tick;
    logic     tad_clr;
    logic     run;

    always_comb begin
        cfg_in.kind = decode_trig(trig_sel);
        cfg_in.samc = samc;
        cfg_in.div  = adcs;
        cfg_in.rc   = rc_sel;
    end

    adc_trig_sel u_trig (
        .kind     (cfg.kind),
        .samp_bit (samp_bit),
        .ext_trig (ext_trig),
        .tmr_trig (tmr_trig),
        .req      (trig_req)
    );

    adc_tad_gen #(.DIV_W(ADCS_W)) u_tad (
        .clk     (clk),
        .rst     (rst),
        .clr     (tad_clr),
        .run     (run),
        .use_rc  (cfg.rc),
        .rc_tick (rc_tick),
        .div     (cfg.div),
        .tick    (tick)
    );

    adc_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .samp_bit    (samp_bit),
        .cfg_in      (cfg_in),
        .trig_req    (trig_req),
        .tick        (tick),
        .conv_data   (conv_data),
        .cfg         (cfg),
        .tad_clr     (tad_clr),
        .run         (run),
        .acq_active  (acq_active),
        .conv_active (conv_active),
        .done        (done),
        .result      (result)
    );

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic [DATA_W-1:0] conv_data,
    input logic              acq_active,
    input logic              conv_active,
    input logic              done,
    input logic [DATA_W-1:0] result
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                             // R7

    AST_DONE_AFTER_CONV: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(conv_active) && !conv_active);                // R7

    AST_RESULT_LOAD: assert property (@(posedge clk) disable iff (rst)
        done |-> result == $past(conv_data));                        // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));                                  // R8

    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !acq_active && !conv_active && !done);           // R8

    AST_CONV_FROM_ACQ: assert property (@(posedge clk) disable iff (rst)
        $rose(conv_active) |-> $past(acq_active) && $past(enable));  // R9

    AST_RESET_IDLE: assert property (@(posedge clk)
        $past(rst) |-> !acq_active && !conv_active && !done);        // R1

endmodule

bind adc_seq_ctrl adc_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .conv_data   (conv_data),
    .acq_active  (acq_active),
    .conv_active (conv_active),
    .done        (done),
    .result      (result)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;

    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          enable;
    logic [2:0]    trig_sel;
    logic          samp_bit;
    logic [4:0]    samc;
    logic [5:0]    adcs;
    logic          rc_sel;
    logic          rc_tick;
    logic          tmr_trig;
    logic          ext_trig;
    logic [DW-1:0] conv_data;
    logic          acq_active;
    logic          conv_active;
    logic          done;
    logic [DW-1:0] result;

    int n_chk  = 0;
    int n_fail = 0;

    localparam int NV = 5;
    localparam int V_ADCS [NV] = '{0, 2, 0, 63, 4};
    localparam int V_SAMC [NV] = '{1, 3, 0, 1, 31};
    localparam int V_DATA [NV] = '{12'h0A5, 12'hFFF, 12'h123, 12'h800, 12'h3C3};

    always #5 clk = ~clk;

    adc_seq_ctrl #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .enable(enable), .trig_sel(trig_sel),
        .samp_bit(samp_bit), .samc(samc), .adcs(adcs), .rc_sel(rc_sel),
        .rc_tick(rc_tick), .tmr_trig(tmr_trig), .ext_trig(ext_trig),
        .conv_data(conv_data), .acq_active(acq_active),
        .conv_active(conv_active), .done(done), .result(result)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_acq(output int n);
        n = 0;
        while (acq_active && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic count_conv(output int n);
        n = 0;
        while (conv_active && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n, m, seen;
        logic [DW-1:0] prev;
        rst = 1'b1; enable = 0; trig_sel = 0; samp_bit = 0; samc = 0; adcs = 0;
        rc_sel = 0; rc_tick = 0; tmr_trig = 0; ext_trig = 0; conv_data = 0;
        step(3);
        chk(!acq_active && !conv_active && !done, "R1 idle in reset", int'(acq_active) + int'(conv_active), 0);
        rst = 1'b0;
        step(1);
        chk(!acq_active && !conv_active && !done, "R1 idle after reset", int'(acq_active) + int'(conv_active), 0);
        chk(result == 0, "R1 result cleared", int'(result), 0);

        // Table walk: automatic mode timing (R2, R4, R7)
        for (int i = 0; i < NV; i++) begin
            int ea;
            ea = ((V_SAMC[i] == 0) ? 1 : V_SAMC[i]) * (V_ADCS[i] + 1);
            trig_sel = 3'b111; adcs = 6'(V_ADCS[i]); samc = 5'(V_SAMC[i]);
            conv_data = DW'(V_DATA[i]); enable = 1; samp_bit = 1;
            step(1);
            samp_bit = 0;
            count_acq(n);
            chk(n == ea, "R4 auto acquisition length", n, ea);
            count_conv(m);
            chk(m == 14 * (V_ADCS[i] + 1), "R2 conversion length", m, 14 * (V_ADCS[i] + 1));
            chk(done == 1'b1, "R7 done at completion", int'(done), 1);
            chk(result == DW'(V_DATA[i]), "R7 result loaded", int'(result), V_DATA[i]);
            chk(acq_active == 1'b1, "R4 auto restart", int'(acq_active), 1);
            step(1);
            chk(done == 1'b0, "R7 done one cycle", int'(done), 0);
            enable = 0;
            step(1);
            chk(!acq_active && !conv_active, "R8 disable stops", int'(acq_active), 0);
        end

        // R9: enable cleared at the auto-start edge
        trig_sel = 3'b111; adcs = 1; samc = 2; enable = 1; samp_bit = 1;
        step(1);
        samp_bit = 0;
        step(3);
        chk(acq_active == 1'b1, "R9 still acquiring", int'(acq_active), 1);
        enable = 0;
        seen = 0;
        for (int k = 0; k < 40; k++) begin
            step(1);
            if (conv_active || done) seen++;
        end
        chk(seen == 0, "R9 no conversion after coincident clear", seen, 0);

        // R8: abort mid-conversion in software mode
        prev = result;
        trig_sel = 3'b000; adcs = 2; conv_data = 12'h555; enable = 1; samp_bit = 1;
        step(1);
        chk(acq_active == 1'b1, "R3 acquisition starts", int'(acq_active), 1);
        step(3);
        samp_bit = 0;
        step(1);
        chk(conv_active == 1'b1, "R3 conversion on bit low", int'(conv_active), 1);
        step(10);
        enable = 0;
        step(1);
        chk(!conv_active && !acq_active, "R8 abort ends phase", int'(conv_active), 0);
        seen = 0;
        for (int k = 0; k < 60; k++) begin
            step(1);
            if (done) seen++;
        end
        chk(seen == 0, "R8 no done after abort", seen, 0);
        chk(result == prev, "R8 result kept", int'(result), int'(prev));
        enable = 1;
        step(5);
        chk(!acq_active, "R8 waits for new trigger", int'(acq_active), 0);

        // R3: full software conversion
        samp_bit = 1; conv_data = 12'h2AB;
        step(1);
        samp_bit = 0;
        step(1);
        count_conv(m);
        chk(m == 42, "R3 software conversion length", m, 42);
        chk(done && result == 12'h2AB, "R3 software result", int'(result), 12'h2AB);
        chk(!acq_active, "R3 no restart in software mode", int'(acq_active), 0);
        step(2);

        // R5: external trigger
        trig_sel = 3'b001; adcs = 0; conv_data = 12'h0E1; samp_bit = 1;
        step(1);
        samp_bit = 0;
        step(2);
        chk(acq_active && !conv_active, "R5 sample bit ignored in ext mode", int'(conv_active), 0);
        tmr_trig = 1; step(1); tmr_trig = 0;
        chk(acq_active && !conv_active, "R5 timer ignored in ext mode", int'(conv_active), 0);
        ext_trig = 1; step(1); ext_trig = 0;
        chk(conv_active == 1'b1, "R5 ext starts conversion", int'(conv_active), 1);
        count_conv(m);
        chk(m == 14 && result == 12'h0E1, "R5 ext conversion", m, 14);
        step(2);

        // R5: timer trigger
        trig_sel = 3'b100; conv_data = 12'h0F2; samp_bit = 1;
        step(1);
        samp_bit = 0;
        ext_trig = 1; step(1); ext_trig = 0;
        chk(acq_active && !conv_active, "R5 ext ignored in timer mode", int'(conv_active), 0);
        tmr_trig = 1; step(1); tmr_trig = 0;
        chk(conv_active == 1'b1, "R5 timer starts conversion", int'(conv_active), 1);
        count_conv(m);
        chk(result == 12'h0F2, "R5 timer result", int'(result), 12'h0F2);
        step(2);

        // R6: oscillator TAD source
        trig_sel = 3'b000; rc_sel = 1; adcs = 5; conv_data = 12'h777; samp_bit = 1;
        step(1);
        samp_bit = 0;
        step(1);
        for (int k = 0; k < 13; k++) begin
            rc_tick = 1; step(1); rc_tick = 0; step(2);
        end
        chk(conv_active && !done, "R6 running after 13 pulses", int'(conv_active), 1);
        rc_tick = 1; step(1); rc_tick = 0;
        chk(done && !conv_active, "R6 ends on 14th pulse", int'(done), 1);
        chk(result == 12'h777, "R6 result", int'(result), 12'h777);
        rc_sel = 0;
        step(2);
        enable = 0;
        step(1);

        // R10: settings changed mid-phase apply at next acquisition
        trig_sel = 3'b111; adcs = 1; samc = 2; enable = 1; samp_bit = 1;
        step(1);
        adcs = 3; samc = 1; samp_bit = 0;
        count_acq(n);
        chk(n == 4, "R10 old acquisition length kept", n, 4);
        count_conv(m);
        chk(m == 28, "R10 old divider kept in conversion", m, 28);
        count_acq(n);
        chk(n == 4, "R10 new acquisition length", n, 4);
        count_conv(m);
        chk(m == 56, "R10 new divider applied", m, 56);
        enable = 0;
        step(2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule